// File: doc/BRIEF.md
# DMA Completion and Drain Tracker

This block follows the responses that come back for DMA transfers in flight. Software or an issuing engine first registers a transfer under a small numeric tag. It gives the total byte count of the transfer and a completion delay of its own. Each response beat then names its tag and the byte size of the request it answers. That requested size, not the possibly rounded-up size of the returned data, is added to the tag's progress count.

When a transfer's progress reaches its total, the transfer stops counting as outstanding. A per-tag timer is then loaded with the response latency plus the transfer's own delay. When the timer expires, a one-cycle completion pulse carries the tag out, and the tag becomes free for reuse. A separate drain pulse marks the moment the last outstanding transfer finishes, so a device can know that no traffic of its own is left in flight.

Top module: `dma_drain_tracker`

## Requirements
- R1: A registration is accepted only when its tag is free and its total is nonzero. A registration on a busy tag, or with a zero total, changes nothing and raises `err_alloc` for one cycle, one clock after it is sampled.
- R2: An accepted response adds `rsp_size` (the requested size) to the byte progress of its tag.
- R3: A response that would take progress past the total, or that names a tag not in the receiving state, is discarded. It raises `err_overflow` for one cycle, one clock after it is sampled.
- R4: The outstanding-transfer count rises by one for each accepted registration. It falls by one only on the response that makes progress equal to the total, and it never falls below zero.
- R5: `drain_done` pulses for one cycle, one clock after a response that brings the outstanding count to zero. It does not pulse if a registration is accepted on the same clock.
- R6: A transfer completed by a response with latency L and registered delay D produces `done_valid` with `done_tag` equal to its tag, for one cycle, L+D+1 clocks after that response is sampled.
- R7: When several tags have expired timers at once, the lowest tag is reported first and the others follow, one per cycle, in ascending tag order.
- R8: A tag becomes free on the clock that issues its completion pulse. A registration sampled on that same clock is still rejected; a later registration on that tag is accepted.
- R9: While reset is held, all outputs are low, every tag is free and the outstanding count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_valid | input | 1 | Register a new transfer this cycle |
| reg_tag | input | TAG_W | Tag of the transfer being registered |
| reg_total | input | LEN_W | Total bytes of the transfer |
| reg_delay | input | DLY_W | Extra completion delay in cycles |
| rsp_valid | input | 1 | A response beat is present |
| rsp_tag | input | TAG_W | Tag the response belongs to |
| rsp_size | input | SIZE_W | Byte size of the original request |
| rsp_lat | input | DLY_W | Response latency in cycles |
| done_valid | output | 1 | Completion pulse |
| done_tag | output | TAG_W | Tag of the completed transfer |
| drain_done | output | 1 | Pulse: no transfers remain outstanding |
| err_overflow | output | 1 | Pulse: response rejected (overrun or idle tag) |
| err_alloc | output | 1 | Pulse: registration rejected |

## Verification
The bench builds the tracker with 3-bit tags (eight slots), 12-bit totals, 8-bit request sizes and 5-bit delays. Timers therefore run up to 62 cycles, and all eight slots can hold pending completions at once. These values bring same-cycle expiry of several tags, re-registration right around a tag's release, and concurrent registration with a final response within reach of both the directed sequences and a long pseudo-random mix. A behavioural model predicts every output on every cycle.

// File: rtl/dma_trk_pkg.sv
// Shared types for the DMA completion tracker.
// Assumes nothing beyond the enum encoding being private to the block.
package dma_trk_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE   = 2'd0,
        SLOT_ACTIVE = 2'd1,
        SLOT_WAIT   = 2'd2
    } slot_state_e;

endpackage

// File: rtl/dma_trk_slot.sv
// One tracking slot: holds the total and progress of a transfer, then a
// countdown until its completion notice may be issued.
// Assumes alloc_i is only raised while the slot is idle and LEN_W >= SIZE_W.
module dma_trk_slot
    import dma_trk_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int SIZE_W = 8,
    parameter int DLY_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [LEN_W-1:0]  total_i,
    input  logic [DLY_W-1:0]  delay_i,
    input  logic              rsp_hit_i,
    input  logic [SIZE_W-1:0] rsp_size_i,
    input  logic [DLY_W-1:0]  rsp_lat_i,
    input  logic              grant_i,
    output logic              busy_o,
    output logic              ready_o,
    output logic              finish_o,
    output logic              reject_o
);
    localparam int SUM_W = LEN_W + 1;
    localparam int TMR_W = DLY_W + 1;

    slot_state_e        state;
    logic [LEN_W-1:0]   total_q;
    logic [LEN_W-1:0]   recvd_q;
    logic [DLY_W-1:0]   delay_q;
    logic [TMR_W-1:0]   timer_q;
    logic [SUM_W-1:0]   sum;
    logic               receiving;

    // Progress the slot would reach with the current response.
    always_comb begin
        sum       = SUM_W'(recvd_q) + SUM_W'(rsp_size_i);
        receiving = (state == SLOT_ACTIVE);
        reject_o  = rsp_hit_i && (!receiving || (sum > SUM_W'(total_q)));
        finish_o  = rsp_hit_i && receiving && (sum == SUM_W'(total_q));
        busy_o    = (state != SLOT_IDLE);
        ready_o   = (state == SLOT_WAIT) && (timer_q == '0);
    end

    // Slot state, progress and completion countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SLOT_IDLE;
            total_q <= '0;
            recvd_q <= '0;
            delay_q <= '0;
            timer_q <= '0;
        end else begin
            unique case (state)
                SLOT_IDLE: begin
                    if (alloc_i) begin
                        state   <= SLOT_ACTIVE;
                        total_q <= total_i;
                        recvd_q <= '0;
                        delay_q <= delay_i;
                    end
                end
                SLOT_ACTIVE: begin
                    if (rsp_hit_i && !reject_o) begin
                        recvd_q <= sum[LEN_W-1:0];
                        if (finish_o) begin
                            state   <= SLOT_WAIT;
                            timer_q <= TMR_W'(rsp_lat_i) + TMR_W'(delay_q);
                        end
                    end
                end
                SLOT_WAIT: begin
                    if (grant_i) begin
                        state <= SLOT_IDLE;
                    end else if (timer_q != '0) begin
                        timer_q <= timer_q - 1'b1;
                    end
                end
                default: state <= SLOT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_trk_pick.sv
// Fixed-priority picker: grants the lowest-numbered requesting slot.
// Assumes N equals 2**IDX_W.
module dma_trk_pick #(
    parameter int IDX_W = 3,
    localparam int N    = 1 << IDX_W
) (
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     grant_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so the lowest request is the one left standing.
    always_comb begin
        idx_o   = '0;
        grant_o = '0;
        any_o   = |req_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        if (any_o) grant_o[idx_o] = 1'b1;
    end

endmodule

// File: rtl/dma_trk_count.sv
// Outstanding-transfer counter with a drain pulse when it falls to zero.
// Assumes dec_i is never raised while the count is zero.
module dma_trk_count #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             drain_o
);
    // Count transfers and flag the step that empties the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            drain_o <= 1'b0;
        end else begin
            unique case ({inc_i, dec_i})
                2'b10:   cnt_o <= cnt_o + 1'b1;
                2'b01:   cnt_o <= cnt_o - 1'b1;
                default: cnt_o <= cnt_o;
            endcase
            drain_o <= dec_i && !inc_i && (cnt_o == CNT_W'(1));
        end
    end

endmodule

// File: rtl/dma_drain_tracker.sv
// Tracks response progress of tagged DMA transfers, issues delayed
// completion notices and a drain pulse when nothing is outstanding.
// Assumes one registration and one response at most per cycle.
module dma_drain_tracker #(
    parameter int TAG_W  = 3,
    parameter int LEN_W  = 12,
    parameter int SIZE_W = 8,
    parameter int DLY_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_valid,
    input  logic [TAG_W-1:0]  reg_tag,
    input  logic [LEN_W-1:0]  reg_total,
    input  logic [DLY_W-1:0]  reg_delay,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [SIZE_W-1:0] rsp_size,
    input  logic [DLY_W-1:0]  rsp_lat,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag,
    output logic              drain_done,
    output logic              err_overflow,
    output logic              err_alloc
);
    localparam int NUM_TAGS = 1 << TAG_W;
    localparam int CNT_W    = TAG_W + 1;

    logic [NUM_TAGS-1:0] slot_busy;
    logic [NUM_TAGS-1:0] slot_ready;
    logic [NUM_TAGS-1:0] slot_finish;
    logic [NUM_TAGS-1:0] slot_reject;
    logic [NUM_TAGS-1:0] slot_grant;
    logic                pick_any;
    logic [TAG_W-1:0]    pick_idx;
    logic                alloc_ok;
    logic                finish_any;
    logic [CNT_W-1:0]    out_cnt;

    // Accept a registration only onto a free tag with a nonzero total.
    always_comb begin
        alloc_ok   = reg_valid && !slot_busy[reg_tag] && (reg_total != '0);
        finish_any = |slot_finish;
    end

    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_slot
        dma_trk_slot #(
            .LEN_W (LEN_W),
            .SIZE_W(SIZE_W),
            .DLY_W (DLY_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .alloc_i   (alloc_ok && (reg_tag == TAG_W'(t))),
            .total_i   (reg_total),
            .delay_i   (reg_delay),
            .rsp_hit_i (rsp_valid && (rsp_tag == TAG_W'(t))),
            .rsp_size_i(rsp_size),
            .rsp_lat_i (rsp_lat),
            .grant_i   (slot_grant[t]),
            .busy_o    (slot_busy[t]),
            .ready_o   (slot_ready[t]),
            .finish_o  (slot_finish[t]),
            .reject_o  (slot_reject[t])
        );
    end

    dma_trk_pick #(
        .IDX_W(TAG_W)
    ) u_pick (
        .req_i  (slot_ready),
        .grant_o(slot_grant),
        .any_o  (pick_any),
        .idx_o  (pick_idx)
    );

    dma_trk_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (alloc_ok),
        .dec_i  (finish_any),
        .cnt_o  (out_cnt),
        .drain_o(drain_done)
    );

    // Register the completion notice and the two error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid   <= 1'b0;
            done_tag     <= '0;
            err_overflow <= 1'b0;
            err_alloc    <= 1'b0;
        end else begin
            done_valid   <= pick_any;
            done_tag     <= pick_idx;
            err_overflow <= |slot_reject;
            err_alloc    <= reg_valid && !alloc_ok;
        end
    end

endmodule

// File: rtl/dma_drain_tracker_chk.sv
// Protocol checks for the DMA completion tracker, bound to its top.
// Assumes it sees the slot busy and grant vectors and the outstanding count.
module dma_drain_tracker_chk #(
    parameter int TAG_W = 3,
    localparam int N    = 1 << TAG_W,
    localparam int CNT_W = TAG_W + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_valid,
    input logic             rsp_valid,
    input logic             done_valid,
    input logic [TAG_W-1:0] done_tag,
    input logic             drain_done,
    input logic             err_overflow,
    input logic             err_alloc,
    input logic [N-1:0]     busy,
    input logic [N-1:0]     grant,
    input logic             finish_any,
    input logic [CNT_W-1:0] cnt
);
    // R1
    alloc_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_alloc |-> $past(reg_valid));

    // R3
    ovf_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |-> $past(rsp_valid));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish_any |-> (cnt != '0));

    // R5
    drain_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> (cnt == '0));

    // R7
    single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R8
    tag_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !busy[done_tag]);

    // R9
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done_valid && !drain_done && !err_overflow && !err_alloc));

endmodule

bind dma_drain_tracker dma_drain_tracker_chk #(
    .TAG_W(TAG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_valid   (reg_valid),
    .rsp_valid   (rsp_valid),
    .done_valid  (done_valid),
    .done_tag    (done_tag),
    .drain_done  (drain_done),
    .err_overflow(err_overflow),
    .err_alloc   (err_alloc),
    .busy        (slot_busy),
    .grant       (slot_grant),
    .finish_any  (finish_any),
    .cnt         (out_cnt)
);

// File: tb/dma_drain_tracker_bench.sv
// Bench: behavioural model of the tracker compared on every clock.
module dma_drain_tracker_bench;
    localparam int TAG_W  = 3;
    localparam int LEN_W  = 12;
    localparam int SIZE_W = 8;
    localparam int DLY_W  = 5;
    localparam int NT     = 1 << TAG_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_valid = 1'b0;
    logic [TAG_W-1:0]  reg_tag = '0;
    logic [LEN_W-1:0]  reg_total = '0;
    logic [DLY_W-1:0]  reg_delay = '0;
    logic              rsp_valid = 1'b0;
    logic [TAG_W-1:0]  rsp_tag = '0;
    logic [SIZE_W-1:0] rsp_size = '0;
    logic [DLY_W-1:0]  rsp_lat = '0;
    logic              done_valid;
    logic [TAG_W-1:0]  done_tag;
    logic              drain_done;
    logic              err_overflow;
    logic              err_alloc;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    bit ended   = 1'b0;

    always #4 clk = ~clk;

    dma_drain_tracker #(
        .TAG_W(TAG_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W), .DLY_W(DLY_W)
    ) u_dma_drain_tracker (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_tag(reg_tag),
        .reg_total(reg_total), .reg_delay(reg_delay),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
        .rsp_size(rsp_size), .rsp_lat(rsp_lat),
        .done_valid(done_valid), .done_tag(done_tag),
        .drain_done(drain_done), .err_overflow(err_overflow),
        .err_alloc(err_alloc)
    );

    // Reference model state: 0 free, 1 receiving, 2 waiting on timer.
    int m_st [NT];
    int m_tot[NT];
    int m_rcv[NT];
    int m_dly[NT];
    int m_tmr[NT];
    int m_cnt;
    bit x_done, x_drain, x_ovf, x_alloc;
    int x_tag;

    // Advance the model on each clock edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NT; t++) begin
                m_st[t] = 0; m_tot[t] = 0; m_rcv[t] = 0; m_dly[t] = 0; m_tmr[t] = 0;
            end
            m_cnt = 0;
            x_done = 0; x_tag = 0; x_drain = 0; x_ovf = 0; x_alloc = 0;
        end else begin
            int g;
            bit ok, comp, ovf;
            g = -1;
            for (int t = 0; t < NT; t++)
                if (g < 0 && m_st[t] == 2 && m_tmr[t] == 0) g = t;
            ok = reg_valid && m_st[reg_tag] == 0 && reg_total != 0;
            comp = 0;
            ovf = 0;
            for (int t = 0; t < NT; t++)
                if (m_st[t] == 2 && m_tmr[t] > 0) m_tmr[t]--;
            if (g >= 0) m_st[g] = 0;
            if (rsp_valid) begin
                int t;
                t = rsp_tag;
                if (m_st[t] != 1 || m_rcv[t] + rsp_size > m_tot[t]) ovf = 1;
                else begin
                    m_rcv[t] += rsp_size;
                    if (m_rcv[t] == m_tot[t]) begin
                        comp = 1;
                        m_st[t] = 2;
                        m_tmr[t] = rsp_lat + m_dly[t];
                    end
                end
            end
            if (ok) begin
                m_st[reg_tag] = 1; m_tot[reg_tag] = reg_total;
                m_rcv[reg_tag] = 0; m_dly[reg_tag] = reg_delay;
            end
            x_done  = (g >= 0);
            x_tag   = (g >= 0) ? g : 0;
            x_drain = comp && !ok && m_cnt == 1;
            m_cnt   = m_cnt + (ok ? 1 : 0) - (comp ? 1 : 0);
            x_ovf   = ovf;
            x_alloc = reg_valid && !ok;
        end
    end

    task automatic check1(string req, int act, int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cycles, act, exp);
        end
    endtask

    // Compare every output with the model between clock edges.
    always @(negedge clk) begin
        cycles++;
        if (!ended) begin
            check1("R6 R7 R8 done_valid", done_valid, x_done);
            if (x_done) check1("R6 R7 done_tag", done_tag, x_tag);
            check1("R4 R5 drain_done", drain_done, x_drain);
            check1("R2 R3 err_overflow", err_overflow, x_ovf);
            check1("R1 R8 err_alloc", err_alloc, x_alloc);
            if (!rst_n) begin
                // R9: outputs quiet while reset is held
                check1("R9 reset outputs",
                    done_valid | drain_done | err_overflow | err_alloc, 0);
            end
        end
        if (cycles == 150000 && !ended) begin
            fails++;
            $display("FAIL R9 watchdog expired: actual running expected finished");
            finish_run();
        end
    end

    task automatic finish_run();
        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reg(int tag, int total, int dly);
        reg_valid = 1'b1; reg_tag = TAG_W'(tag);
        reg_total = LEN_W'(total); reg_delay = DLY_W'(dly);
        @(negedge clk);
        reg_valid = 1'b0;
    endtask

    task automatic do_rsp(int tag, int size, int lat);
        rsp_valid = 1'b1; rsp_tag = TAG_W'(tag);
        rsp_size = SIZE_W'(size); rsp_lat = DLY_W'(lat);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    task automatic do_both(int rtag, int total, int dly, int ptag, int size, int lat);
        reg_valid = 1'b1; reg_tag = TAG_W'(rtag);
        reg_total = LEN_W'(total); reg_delay = DLY_W'(dly);
        rsp_valid = 1'b1; rsp_tag = TAG_W'(ptag);
        rsp_size = SIZE_W'(size); rsp_lat = DLY_W'(lat);
        @(negedge clk);
        reg_valid = 1'b0; rsp_valid = 1'b0;
    endtask

    initial begin
        int seed;
        seed = 32'h1d2c_3b4a;
        // R9: hold reset for several cycles
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R2 R4 R5 R6: three chunks summing to the total, delayed notice
        do_reg(0, 64, 3);
        do_rsp(0, 16, 2);
        do_rsp(0, 16, 2);
        do_rsp(0, 32, 2);
        idle(8);

        // R3: overrun rejected, then exact fit completes
        do_reg(1, 10, 0);
        do_rsp(1, 12, 0);
        do_rsp(1, 10, 0);
        idle(3);

        // R3: response to a free tag
        do_rsp(6, 8, 0);
        idle(2);

        // R1: busy tag and zero total rejected
        do_reg(2, 8, 0);
        do_reg(2, 16, 0);
        do_reg(3, 0, 0);
        do_rsp(2, 8, 0);
        idle(3);

        // R7: two timers expiring together, lower tag first
        do_reg(2, 8, 2);
        do_reg(5, 8, 1);
        do_rsp(2, 8, 0);
        do_rsp(5, 8, 0);
        idle(6);

        // R5: registration alongside the final response suppresses drain
        do_reg(3, 8, 0);
        do_both(4, 8, 0, 3, 8, 0);
        idle(3);
        do_rsp(4, 8, 0);
        idle(3);

        // R8: re-register a tag around its release
        do_reg(0, 8, 0);
        do_rsp(0, 8, 0);
        do_reg(0, 8, 0);
        do_reg(0, 8, 0);
        do_rsp(0, 8, 1);
        idle(4);

        // R1-style mixed traffic: pseudo-random registrations and responses
        for (int i = 0; i < 3000; i++) begin
            seed = seed * 1103515245 + 12345;
            reg_valid = seed[20];
            reg_tag   = TAG_W'(seed[18:16]);
            reg_total = LEN_W'(8 * (1 + seed[24:22]));
            reg_delay = DLY_W'(seed[29:26] & 4'hF);
            seed = seed * 1103515245 + 12345;
            rsp_valid = seed[17] | seed[21];
            rsp_tag   = TAG_W'(seed[26:24]);
            rsp_size  = seed[28] ? SIZE_W'(16) : SIZE_W'(8);
            rsp_lat   = DLY_W'(seed[22:19]);
            @(negedge clk);
        end
        reg_valid = 1'b0;
        rsp_valid = 1'b0;
        idle(80);
        finish_run();
    end

endmodule